// File: doc/BRIEF.md
# Cascaded Sixteen-Line Interrupt Controller

This block takes sixteen interrupt request lines and merges them into one interrupt output for a processor. Two identical eight-line controller cores do the work. The primary core owns lines 0 to 7. The secondary core owns lines 8 to 15. The secondary core's "has a request" result is fed into input 2 of the primary core, so the secondary appears to the primary as a single request on that input. Software programs both cores through a byte-wide register bus decoded from a 16-bit address. Each core also has a trigger-mode register that selects edge or level sensing per line.

When the processor acknowledges with a one-cycle `int_ack` strobe, the block resolves the winning request. It then returns an 8-bit vector one cycle later. That vector may come from the secondary core, when the primary selects input 2. When nothing is pending, the vector is the spurious code of the chip concerned. Priority is fixed: a lower line number beats a higher one. A request is presented only when it outranks everything already in service in that core. In-service bits are released by end-of-interrupt commands, or automatically if the core was initialised for that. A polling read returns the winner without using the acknowledge path.

Top module: `pic_cascade_pair`

## Requirements
- R1: Address decode.
  - Six addresses are decoded. 0x0020/0x0021 are the primary command/data ports. 0x00A0/0x00A1 are the secondary command/data ports. 0x04D0/0x04D1 are the primary/secondary trigger-mode registers.
  - A write to any other address changes nothing.
  - A read from any other address returns 0xFF.
- R2: Trigger-mode registers.
  - A write stores the data ANDed with a fixed mask: 0xF8 for the primary, 0xDE for the secondary.
  - A read returns the stored value.
  - Bit k = 1 makes line k of that chip level-sensed. Bit k = 0 makes it edge-sensed.
- R3: Line routing and the cascade input.
  - Request line n goes to chip n>>3, input n&7.
  - External line 2 has no effect. Primary input 2 is driven only by the cascade.
- R4: Initialisation and mask register.
  - A command-port write with bit 4 set starts initialisation. It clears the mask register and in-service register, and keeps only level-mode request bits. Its bit 0 says whether a fourth byte follows.
  - The next data byte sets the vector base, from bits 7:3.
  - The third data byte is ignored.
  - The optional fourth data byte sets automatic end-of-interrupt from its bit 1. With automatic end-of-interrupt, an acknowledge leaves the in-service bit clear.
  - Outside initialisation, a data-port write sets the mask register. Bit k = 1 masks line k.
- R5: Fixed priority. The lowest-numbered unmasked pending line wins. It is presented only if its number is lower than every in-service line of that chip.
- R6: Request latching.
  - An edge-mode line latches a request on a low-to-high transition. The request is cleared by acknowledge, not by the line falling.
  - A level-mode request bit follows the line and is not cleared by acknowledge.
- R7: Cascade update.
  - An update occurs one cycle after any bus write, polling read, acknowledge or request-line change.
  - On the cycle after an update, if the secondary has a presentable request, primary input 2 is driven high for one cycle. Otherwise it is driven low.
- R8: `cpu_int` is high exactly when the primary has a presentable request.
- R9: Acknowledge result.
  - `ack_valid` is high in the cycle after `int_ack`, and `ack_vector` is valid in that cycle.
  - For a primary winner other than input 2, the vector is the primary base with the line in bits 2:0.
  - The winner's in-service bit is set, and an edge-mode request bit is cleared.
- R10: Acknowledge through the cascade. When the primary wins with input 2, the secondary is also acknowledged. The vector is the secondary base plus the secondary line, or the secondary base plus 7 if the secondary has nothing presentable.
- R11: With nothing presentable on the primary, the vector is the primary base plus 7. No state changes.
- R12: Command-port operations.
  - Command-port write with bits 4:3 = 00 and bits 7:5 = 001: clears the highest-priority in-service bit.
  - Same, with bits 7:5 = 011: clears the in-service bit given by bits 2:0.
  - Command-port write with bit 3 set: bit 2 arms a poll. If bit 1 is set, bit 0 selects what a command-port read returns: 1 for the in-service register, 0 for the request register.
- R13: Polling read.
  - A read from either port of a chip with an armed poll returns 0x80 plus the winning line, acknowledges that line and disarms the poll. It returns 0x07 if nothing is presentable.
  - A secondary poll that returns a line also clears primary in-service and request bit 2.
- R14: Reset state.
  - After reset, every register is zero and `cpu_int` and `ack_valid` are low.
  - A data-port read returns 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_lines | input | 16 | Request lines 0 to 15 |
| bus_addr | input | 16 | Register address |
| bus_wr | input | 1 | One-cycle write strobe |
| bus_rd | input | 1 | One-cycle read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid the cycle after `bus_rd` |
| int_ack | input | 1 | One-cycle acknowledge strobe |
| ack_vector | output | 8 | Vector returned for the acknowledge |
| ack_valid | output | 1 | High the cycle after `int_ack` |
| cpu_int | output | 1 | Interrupt request to the processor |

## Verification
Results become due at different times after a stimulus:

| Result | When it is due |
|---|---|
| Read data and the acknowledge vector | One clock edge after the strobe |
| `cpu_int`, for a primary line, a register write or an end-of-interrupt | One edge later |
| `cpu_int`, for a secondary line | Three edges later: secondary latch, then cascade pulse, then primary latch |

The bench drives every input on a falling edge and samples at a later falling edge. It allows at least four cycles wherever the cascade path is involved, so no check lands on a cycle where the result is still in flight.

// File: rtl/pic_pkg.sv
package pic_pkg;

  // lines handled by one controller core
  localparam int CHIP_LINES = 8;
  // number of cores in the cascade
  localparam int NCHIP = 2;
  // primary input that carries the secondary's request
  localparam int CASC_IN = 2;

  typedef enum logic [1:0] {
    INIT_IDLE = 2'd0,
    INIT_BASE = 2'd1,
    INIT_LINK = 2'd2,
    INIT_MODE = 2'd3
  } init_st_e;

endpackage

// File: rtl/pic_trig_reg.sv
module pic_trig_reg #(
  parameter int W = 8,
  parameter logic [W-1:0] MASK = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q
);

  logic [W-1:0] q_n;

  always_comb begin
    q_n = q;
    if (wr_en) q_n = wdata & MASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_n;
  end

  // R2
  trig_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (q == ($past(wdata) & MASK)));

  // R1
  trig_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(q));

endmodule

// File: rtl/pic_chip_core.sv
module pic_chip_core
  import pic_pkg::*;
#(
  parameter int LINES = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] req_in,
  input  logic [LINES-1:0] trig,
  input  logic             cmd_wr,
  input  logic             data_wr,
  input  logic [7:0]       wdata,
  input  logic             ack_en,
  input  logic             poll_rd,
  input  logic             clr_casc,
  output logic [LINES-1:0] irr_o,
  output logic [LINES-1:0] isr_o,
  output logic [LINES-1:0] imr_o,
  output logic [7-$clog2(LINES):0] base_o,
  output logic             has_o,
  output logic [$clog2(LINES)-1:0] win_o,
  output logic             poll_o,
  output logic             rd_isr_o
);

  localparam int IW = $clog2(LINES);
  localparam int BW = 8 - IW;

  logic [LINES-1:0] irr_q, irr_n, isr_q, isr_n, imr_q, imr_n, last_q, last_n;
  logic [BW-1:0]    base_q, base_n;
  logic             init4_q, init4_n, aeoi_q, aeoi_n;
  logic             poll_q, poll_n, rdisr_q, rdisr_n;
  init_st_e         st_q, st_n;

  logic [LINES-1:0] pend;
  logic [IW-1:0]    win, isr_top;
  logic             has, take;

  // resolve winner and highest in-service line (lowest index first)
  assign pend = irr_q & ~imr_q;

  always_comb begin
    win = '0;
    for (int i = LINES - 1; i >= 0; i--)
      if (pend[i]) win = IW'(i);
  end

  always_comb begin
    isr_top = '0;
    for (int i = LINES - 1; i >= 0; i--)
      if (isr_q[i]) isr_top = IW'(i);
  end

  assign has  = (|pend) && ((isr_q == '0) || (win < isr_top));
  assign take = (ack_en || poll_rd) && has;

  always_comb begin
    irr_n   = irr_q;
    isr_n   = isr_q;
    imr_n   = imr_q;
    last_n  = req_in;
    base_n  = base_q;
    init4_n = init4_q;
    aeoi_n  = aeoi_q;
    poll_n  = poll_q;
    rdisr_n = rdisr_q;
    st_n    = st_q;

    // request sampling
    for (int i = 0; i < LINES; i++) begin
      if (trig[i])                       irr_n[i] = req_in[i];
      else if (req_in[i] && !last_q[i])  irr_n[i] = 1'b1;
    end

    // acknowledge (bus or poll)
    if (take) begin
      if (!aeoi_q)    isr_n[win] = 1'b1;
      if (!trig[win]) irr_n[win] = 1'b0;
    end
    if (poll_rd) poll_n = 1'b0;

    if (clr_casc) begin
      isr_n[CASC_IN] = 1'b0;
      irr_n[CASC_IN] = 1'b0;
    end

    if (cmd_wr) begin
      if (wdata[4]) begin
        init4_n = wdata[0];
        imr_n   = '0;
        isr_n   = '0;
        irr_n   = irr_n & trig;
        last_n  = '0;
        poll_n  = 1'b0;
        rdisr_n = 1'b0;
        if (!wdata[0]) aeoi_n = 1'b0;
        st_n    = INIT_BASE;
      end else if (wdata[3]) begin
        if (wdata[2]) poll_n  = 1'b1;
        if (wdata[1]) rdisr_n = wdata[0];
      end else begin
        case (wdata[7:5])
          3'b001:  if (isr_q != '0) isr_n[isr_top] = 1'b0;
          3'b011:  isr_n[wdata[IW-1:0]] = 1'b0;
          default: ;
        endcase
      end
    end

    if (data_wr) begin
      case (st_q)
        INIT_IDLE: imr_n = wdata[LINES-1:0];
        INIT_BASE: begin
          base_n = wdata[7:IW];
          st_n   = INIT_LINK;
        end
        INIT_LINK: st_n = init4_q ? INIT_MODE : INIT_IDLE;
        INIT_MODE: begin
          aeoi_n = wdata[1];
          st_n   = INIT_IDLE;
        end
        default:   st_n = INIT_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irr_q   <= '0;
      isr_q   <= '0;
      imr_q   <= '0;
      last_q  <= '0;
      base_q  <= '0;
      init4_q <= 1'b0;
      aeoi_q  <= 1'b0;
      poll_q  <= 1'b0;
      rdisr_q <= 1'b0;
      st_q    <= INIT_IDLE;
    end else begin
      irr_q   <= irr_n;
      isr_q   <= isr_n;
      imr_q   <= imr_n;
      last_q  <= last_n;
      base_q  <= base_n;
      init4_q <= init4_n;
      aeoi_q  <= aeoi_n;
      poll_q  <= poll_n;
      rdisr_q <= rdisr_n;
      st_q    <= st_n;
    end
  end

  assign irr_o    = irr_q;
  assign isr_o    = isr_q;
  assign imr_o    = imr_q;
  assign base_o   = base_q;
  assign has_o    = has;
  assign win_o    = win;
  assign poll_o   = poll_q;
  assign rd_isr_o = rdisr_q;

  // R9
  ack_isr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_en && has && !aeoi_q && !cmd_wr && !clr_casc) |=> isr_q[$past(win)]);

  // R6
  edge_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !trig[win] && !cmd_wr) |=> !irr_q[$past(win)]);

  // R4
  mask_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && !cmd_wr && st_q == INIT_IDLE) |=> imr_q == $past(wdata[LINES-1:0]));

endmodule

// File: rtl/pic_cascade_pair.sv
module pic_cascade_pair
  import pic_pkg::*;
#(
  parameter int AW = 16,
  parameter logic [AW-1:0] M_CMD_ADDR  = 16'h0020,
  parameter logic [AW-1:0] M_DATA_ADDR = 16'h0021,
  parameter logic [AW-1:0] S_CMD_ADDR  = 16'h00A0,
  parameter logic [AW-1:0] S_DATA_ADDR = 16'h00A1,
  parameter logic [AW-1:0] M_TRIG_ADDR = 16'h04D0,
  parameter logic [AW-1:0] S_TRIG_ADDR = 16'h04D1,
  parameter logic [7:0]    M_TRIG_MASK = 8'hF8,
  parameter logic [7:0]    S_TRIG_MASK = 8'hDE
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NCHIP*CHIP_LINES-1:0]   irq_lines,
  input  logic [AW-1:0]                 bus_addr,
  input  logic                          bus_wr,
  input  logic                          bus_rd,
  input  logic [7:0]                    bus_wdata,
  output logic [7:0]                    bus_rdata,
  input  logic                          int_ack,
  output logic [7:0]                    ack_vector,
  output logic                          ack_valid,
  output logic                          cpu_int
);

  localparam int NLINE = NCHIP * CHIP_LINES;
  localparam int IW    = $clog2(CHIP_LINES);
  localparam int BW    = 8 - IW;

  logic [CHIP_LINES-1:0] core_req [NCHIP];
  logic [CHIP_LINES-1:0] trig_q   [NCHIP];
  logic [CHIP_LINES-1:0] irr      [NCHIP];
  logic [CHIP_LINES-1:0] isr      [NCHIP];
  logic [CHIP_LINES-1:0] imr      [NCHIP];
  logic [BW-1:0]         base     [NCHIP];
  logic [IW-1:0]         win      [NCHIP];
  logic [7:0]            poll_byte[NCHIP];
  logic [NCHIP-1:0] has, poll_arm, rd_isr;
  logic [NCHIP-1:0] cmd_hit, data_hit, trig_hit;
  logic [NCHIP-1:0] cmd_wr, data_wr, trig_wr, ack_en, poll_rd, clr_casc;

  logic             any_hit;
  logic [NLINE-1:0] lines_q;
  logic             upd_q, upd_n, casc_q, casc_n;
  logic [7:0]       rdata_q, rdata_n, rd_mux;
  logic [7:0]       vec_q, vec_n, vec_sel;
  logic             ackv_q, ackv_n;

  generate
    for (genvar c = 0; c < NCHIP; c++) begin : g_chip
      localparam logic [AW-1:0] CADDR = (c == 0) ? M_CMD_ADDR  : S_CMD_ADDR;
      localparam logic [AW-1:0] DADDR = (c == 0) ? M_DATA_ADDR : S_DATA_ADDR;
      localparam logic [AW-1:0] TADDR = (c == 0) ? M_TRIG_ADDR : S_TRIG_ADDR;
      localparam logic [7:0]    TMASK = (c == 0) ? M_TRIG_MASK : S_TRIG_MASK;

      assign cmd_hit[c]  = (bus_addr == CADDR);
      assign data_hit[c] = (bus_addr == DADDR);
      assign trig_hit[c] = (bus_addr == TADDR);
      assign cmd_wr[c]   = bus_wr && cmd_hit[c];
      assign data_wr[c]  = bus_wr && data_hit[c];
      assign trig_wr[c]  = bus_wr && trig_hit[c];
      assign poll_rd[c]  = bus_rd && (cmd_hit[c] || data_hit[c]) && poll_arm[c];
      assign poll_byte[c] = has[c] ? {1'b1, {(7-IW){1'b0}}, win[c]} : 8'h07;

      pic_trig_reg #(
        .W    (CHIP_LINES),
        .MASK (TMASK)
      ) u_trig (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (trig_wr[c]),
        .wdata (bus_wdata),
        .q     (trig_q[c])
      );

      pic_chip_core #(
        .LINES (CHIP_LINES)
      ) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_in   (core_req[c]),
        .trig     (trig_q[c]),
        .cmd_wr   (cmd_wr[c]),
        .data_wr  (data_wr[c]),
        .wdata    (bus_wdata),
        .ack_en   (ack_en[c]),
        .poll_rd  (poll_rd[c]),
        .clr_casc (clr_casc[c]),
        .irr_o    (irr[c]),
        .isr_o    (isr[c]),
        .imr_o    (imr[c]),
        .base_o   (base[c]),
        .has_o    (has[c]),
        .win_o    (win[c]),
        .poll_o   (poll_arm[c]),
        .rd_isr_o (rd_isr[c])
      );
    end
  endgenerate

  assign any_hit = |{cmd_hit, data_hit, trig_hit};

  // line routing: chip n>>3, input n&7; primary cascade input from the pulse
  always_comb begin
    for (int c = 0; c < NCHIP; c++)
      core_req[c] = irq_lines[c*CHIP_LINES +: CHIP_LINES];
    core_req[0][CASC_IN] = casc_q;
  end

  // acknowledge routing
  always_comb begin
    ack_en      = '0;
    clr_casc    = '0;
    ack_en[0]   = int_ack;
    ack_en[1]   = int_ack && has[0] && (win[0] == IW'(CASC_IN));
    clr_casc[0] = poll_rd[1] && has[1];
  end

  always_comb begin
    if (!has[0])                        vec_sel = {base[0], {IW{1'b1}}};
    else if (win[0] == IW'(CASC_IN))    vec_sel = has[1] ? {base[1], win[1]}
                                                         : {base[1], {IW{1'b1}}};
    else                                vec_sel = {base[0], win[0]};
  end

  // read mux
  always_comb begin
    rd_mux = 8'hFF;
    for (int c = 0; c < NCHIP; c++) begin
      if (cmd_hit[c] || data_hit[c]) begin
        if (poll_arm[c])   rd_mux = poll_byte[c];
        else if (cmd_hit[c]) rd_mux = rd_isr[c] ? isr[c] : irr[c];
        else               rd_mux = imr[c];
      end
      if (trig_hit[c]) rd_mux = trig_q[c];
    end
  end

  // next state: update strobe, cascade pulse, bus/ack outputs
  always_comb begin
    upd_n   = bus_wr || (|poll_rd) || int_ack || (irq_lines != lines_q);
    casc_n  = upd_q && has[1];
    rdata_n = bus_rd ? rd_mux : rdata_q;
    vec_n   = int_ack ? vec_sel : vec_q;
    ackv_n  = int_ack;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lines_q <= '0;
      upd_q   <= 1'b0;
      casc_q  <= 1'b0;
      rdata_q <= '0;
      vec_q   <= '0;
      ackv_q  <= 1'b0;
    end else begin
      lines_q <= irq_lines;
      upd_q   <= upd_n;
      casc_q  <= casc_n;
      rdata_q <= rdata_n;
      vec_q   <= vec_n;
      ackv_q  <= ackv_n;
    end
  end

  assign bus_rdata  = rdata_q;
  assign ack_vector = vec_q;
  assign ack_valid  = ackv_q;
  assign cpu_int    = has[0];

  // R9
  ack_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int_ack |=> ack_valid);

  // R9
  ack_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !int_ack |=> !ack_valid);

  // R11
  spurious_primary_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int_ack && !has[0]) |=> ack_vector == {$past(base[0]), {IW{1'b1}}});

  // R1
  unmapped_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !any_hit) |=> bus_rdata == 8'hFF);

  // R7
  casc_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(casc_q) |-> $past(has[1]));

endmodule

// File: tb/pic_cascade_pair_tb.sv
module pic_cascade_pair_tb;

  localparam int CLK_P = 10;
  localparam logic [7:0] MBASE = 8'h40;
  localparam logic [7:0] SBASE = 8'h70;

  logic        clk;
  logic        rst_n;
  logic [15:0] irq_lines;
  logic [15:0] bus_addr;
  logic        bus_wr, bus_rd, int_ack;
  logic [7:0]  bus_wdata;
  logic [7:0]  bus_rdata, ack_vector;
  logic        ack_valid, cpu_int;

  int n_tests;
  int n_fail;

  pic_cascade_pair u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .irq_lines  (irq_lines),
    .bus_addr   (bus_addr),
    .bus_wr     (bus_wr),
    .bus_rd     (bus_rd),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .int_ack    (int_ack),
    .ack_vector (ack_vector),
    .ack_valid  (ack_valid),
    .cpu_int    (cpu_int)
  );

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  function automatic logic [7:0] exp_vec(input int n);
    return (n < 8) ? (MBASE | 8'(n & 7)) : (SBASE | 8'(n & 7));
  endfunction

  function automatic logic [7:0] exp_trig(input logic [15:0] a, input logic [7:0] d);
    return (a == 16'h04D0) ? (d & 8'hF8) : (d & 8'hDE);
  endfunction

  function automatic bit is_mapped(input logic [15:0] a);
    return a == 16'h0020 || a == 16'h0021 || a == 16'h00A0 ||
           a == 16'h00A1 || a == 16'h04D0 || a == 16'h04D1;
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [7:0] d);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic ack(output logic [7:0] v);
    int_ack = 1'b1;
    @(negedge clk);
    int_ack = 1'b0;
    check("R9 ack_valid", {7'd0, ack_valid}, 8'd1);
    v = ack_vector;
  endtask

  task automatic init_chip(input logic [15:0] cmd, input logic [7:0] base, input logic [7:0] mode);
    wr(cmd, 8'h11);
    wr(cmd + 16'd1, base);
    wr(cmd + 16'd1, 8'h04);
    wr(cmd + 16'd1, mode);
  endtask

  initial begin
    #(CLK_P * 150000);
    n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [7:0]  d, v;
    logic [15:0] a;
    n_tests = 0; n_fail = 0;
    rst_n = 1'b0; irq_lines = '0; bus_addr = '0; bus_wr = 0; bus_rd = 0;
    bus_wdata = '0; int_ack = 0;
    void'($urandom(32'd2024));
    idle(3);
    rst_n = 1'b1;
    idle(2);

    // R14 reset state
    check("R14 cpu_int", {7'd0, cpu_int}, 8'd0);
    check("R14 ack_valid", {7'd0, ack_valid}, 8'd0);
    rd(16'h0021, d); check("R14 primary mask", d, 8'h00);
    rd(16'h04D1, d); check("R14 secondary trig", d, 8'h00);

    // R4 initialisation
    init_chip(16'h0020, MBASE, 8'h01);
    init_chip(16'h00A0, SBASE, 8'h01);
    rd(16'h0021, d); check("R4 mask after init", d, 8'h00);

    // R11 nothing pending
    idle(2);
    check("R8 idle cpu_int", {7'd0, cpu_int}, 8'd0);
    ack(v); check("R11 primary spurious", v, MBASE | 8'h07);

    // R2 trigger registers, random
    for (int i = 0; i < 20; i++) begin
      a = ($urandom % 2) ? 16'h04D1 : 16'h04D0;
      d = 8'($urandom);
      wr(a, d);
      rd(a, v); check("R2 trig masked write", v, exp_trig(a, d));
    end
    wr(16'h04D0, 8'h00); wr(16'h04D1, 8'h00);

    // R1 unmapped addresses
    for (int i = 0; i < 10; i++) begin
      a = 16'($urandom);
      if (is_mapped(a)) a = a ^ 16'h0100;
      wr(a, 8'($urandom));
      rd(a, d); check("R1 unmapped read", d, 8'hFF);
    end
    rd(16'h0021, d); check("R1 primary mask untouched", d, 8'h00);
    rd(16'h00A1, d); check("R1 secondary mask untouched", d, 8'h00);
    rd(16'h04D0, d); check("R1 primary trig untouched", d, 8'h00);

    // R3 R9 R10 R12 random single requests
    for (int i = 0; i < 30; i++) begin
      int n;
      n = $urandom % 16;
      if (n == 2) n = 3;
      irq_lines[n] = 1'b1;
      idle(5);
      check("R8 cpu_int raised", {7'd0, cpu_int}, 8'd1);
      ack(v); check("R3 R9 R10 vector", v, exp_vec(n));
      irq_lines[n] = 1'b0;
      wr(16'h0020, 8'h0B);
      rd(16'h0020, d);
      check("R9 primary in-service", d, (n < 8) ? 8'(1 << n) : 8'h04);
      if (n >= 8) wr(16'h00A0, 8'h20);
      wr(16'h0020, 8'h20);
      idle(5);
      check("R12 cleared cpu_int", {7'd0, cpu_int}, 8'd0);
    end

    // R5 priority and nesting
    irq_lines[5] = 1'b1; irq_lines[3] = 1'b1;
    idle(3);
    ack(v); check("R5 lower line wins", v, MBASE | 8'h03);
    idle(2);
    check("R5 lower priority held off", {7'd0, cpu_int}, 8'd0);
    wr(16'h0020, 8'h20);
    idle(2);
    check("R12 eoi releases", {7'd0, cpu_int}, 8'd1);
    ack(v); check("R5 next line", v, MBASE | 8'h05);
    wr(16'h0020, 8'h65);
    wr(16'h0020, 8'h0B);
    rd(16'h0020, d); check("R12 specific eoi", d, 8'h00);
    irq_lines = '0;
    idle(3);

    // R10 secondary spurious, then R7 re-evaluation on unmask
    irq_lines[9] = 1'b1;
    idle(5);
    check("R7 cascade raises", {7'd0, cpu_int}, 8'd1);
    wr(16'h00A1, 8'h02);
    idle(4);
    ack(v); check("R10 secondary spurious", v, SBASE | 8'h07);
    wr(16'h0020, 8'h20);
    idle(4);
    check("R7 masked secondary quiet", {7'd0, cpu_int}, 8'd0);
    wr(16'h00A1, 8'h00);
    idle(5);
    check("R7 unmask re-pulses", {7'd0, cpu_int}, 8'd1);
    ack(v); check("R10 secondary vector", v, SBASE | 8'h01);
    irq_lines[9] = 1'b0;
    wr(16'h00A0, 8'h20); wr(16'h0020, 8'h20);
    idle(4);

    // R6 level mode on primary line 3
    wr(16'h04D0, 8'h08);
    irq_lines[3] = 1'b1;
    idle(3);
    ack(v); check("R6 level vector", v, MBASE | 8'h03);
    wr(16'h0020, 8'h20);
    idle(2);
    check("R6 level stays pending", {7'd0, cpu_int}, 8'd1);
    irq_lines[3] = 1'b0;
    idle(2);
    check("R6 level follows line", {7'd0, cpu_int}, 8'd0);
    wr(16'h04D0, 8'h00);
    idle(2);

    // R13 secondary poll
    irq_lines[12] = 1'b1;
    idle(5);
    wr(16'h00A0, 8'h0C);
    idle(4);
    rd(16'h00A0, d); check("R13 secondary poll", d, 8'h84);
    idle(4);
    check("R13 cascade bit cleared", {7'd0, cpu_int}, 8'd0);
    irq_lines[12] = 1'b0;
    wr(16'h00A0, 8'h20);
    wr(16'h0020, 8'h0C);
    rd(16'h0020, d); check("R13 poll nothing", d, 8'h07);
    wr(16'h0020, 8'h0B);
    rd(16'h0020, d); check("R13 primary isr clear", d, 8'h00);

    // R3 external line 2 ignored
    irq_lines[2] = 1'b1;
    idle(5);
    check("R3 line 2 ignored", {7'd0, cpu_int}, 8'd0);
    irq_lines[2] = 1'b0;
    idle(2);

    // R4 automatic end-of-interrupt
    init_chip(16'h0020, MBASE, 8'h03);
    irq_lines[4] = 1'b1;
    idle(3);
    ack(v); check("R4 auto-eoi vector", v, MBASE | 8'h04);
    wr(16'h0020, 8'h0B);
    rd(16'h0020, d); check("R4 auto-eoi isr", d, 8'h00);
    irq_lines[4] = 1'b0;
    idle(3);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule